// File: doc/BRIEF.md
# Supply-Mode Switch Stall Handshake Controller

This controller sequences a change of supply voltage between a low-power (sub-threshold) setting and a performance (near-threshold) setting. It guards logic that must not run while the rail is in transit, for example a memory buffer or a small processor. When the requested mode differs from the mode that is applied, it first raises a stall request toward the guarded logic. It then waits until that logic confirms it has stopped, and only after this confirmation flips the supply select. The stall stays up until the supply reports that the new rail is fully connected. The guarded logic keeps its stored contents through the whole sequence.

The state machine moves through five named states. IDLE compares the requested mode with the applied one (IDLE to STALL_REQ on a difference). STALL_REQ holds the stall and waits for the confirmation (STALL_REQ to SWITCHING on `stall_done`, flipping the select on that edge). SWITCHING waits for the supply-ready indication to drop (SWITCHING to WAIT_READY). WAIT_READY waits for it to return (WAIT_READY to RELEASE). RELEASE drops the stall for one cycle before going back to IDLE (RELEASE to IDLE). A request that changes during a sequence is kept and served once IDLE is reached again. A programmable watchdog flags handshakes that take too long.

Top module: `dvs_stall_ctrl`

## Requirements
- R1: After a synchronous reset, `stall`, `busy`, `supply_sel` and `timeout_err` are all 0. `supply_sel` 0 means the low-power supply and 1 means the performance supply; `mode_req` uses the same encoding.
- R2: When `mode_req` changes while IDLE, `stall` and `busy` rise exactly three clock edges after the change (two synchronizer stages and one state edge). `supply_sel` is unchanged at that point.
- R3: `supply_sel` never changes while `stall_done` is low. It flips on the first clock edge at which the controller is in STALL_REQ with `stall_done` high.
- R4: After the select flips, `stall` stays high until `supply_ready` has been seen low and then high. It falls three edges after `supply_ready` rises.
- R5: `busy` is high in every state except IDLE. It stays high for exactly one cycle after `stall` falls (RELEASE).
- R6: Sequences never overlap. A `mode_req` change made during a sequence is served by a fresh sequence after IDLE is reached, provided the requested mode then differs from the applied one. A change that returns to the applied mode before IDLE starts no sequence.
- R7: With a non-zero `timeout_lim` of N, if `stall_done` has not arrived, `timeout_err` rises on the (N+1)th edge after `stall` rose. `stall` stays high, and the flag holds until reset.
- R8: The same watchdog covers the supply: a `supply_ready` that never returns raises `timeout_err` while `stall` stays high.
- R9: A `timeout_lim` of 0 disables the watchdog, so `timeout_err` stays 0 however long a handshake lasts.
- R10: `stall_done` has no effect while IDLE: `supply_sel` and `stall` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_req | input | 1 | Requested mode, asynchronous (0 low-power, 1 performance) |
| stall_done | input | 1 | Guarded logic confirms it has stopped |
| supply_ready | input | 1 | New rail fully connected, asynchronous |
| timeout_lim | input | CNT_W | Watchdog limit in cycles, 0 disables |
| stall | output | 1 | Stall request to guarded logic |
| supply_sel | output | 1 | Applied supply (0 low-power, 1 performance) |
| busy | output | 1 | A mode sequence is in progress |
| timeout_err | output | 1 | Sticky watchdog flag |

## Verification
The hardest situation to reach from the ports is a mode request that changes while a sequence is still in flight. The change has to cross the two-stage synchronizer and land between the stall rising and the return to IDLE. Slow handshake models for the guarded logic and the supply stretch that window. Directed stimulus toggles the request once, and also twice, inside it. A random phase then varies the handshake delays and the toggle spacing, and a monitor enforces the ordering rules on every cycle.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_STALL_REQ  = 3'd1,
        S_SWITCHING  = 3'd2,
        S_WAIT_READY = 3'd3,
        S_RELEASE    = 3'd4
    } dvs_state_t;
endpackage

// File: rtl/dvs_sync.sv
module dvs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dvs_watchdog.sv
module dvs_watchdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             waiting,
    input  logic             leaving,
    input  logic [CNT_W-1:0] limit,
    output logic             err
);
    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign expire = waiting && !leaving && (limit != '0) && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!waiting || leaving) begin
            cnt <= '0;
        end else if (cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         err <= 1'b0;
        else if (expire) err <= 1'b1;
    end

    // R7: flag is sticky until reset
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        $past(err) |-> err);
    // R9: a zero limit never raises the flag
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (limit == '0 && $past(limit) == '0 && !$past(err)) |-> !err);
endmodule

// File: rtl/dvs_fsm.sv
module dvs_fsm
    import dvs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_s,
    input  logic ready_s,
    input  logic stall_done,
    output logic stall,
    output logic busy,
    output logic supply_sel,
    output logic waiting,
    output logic leaving
);
    dvs_state_t state, nxt;
    logic       applied;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (mode_s != applied) nxt = S_STALL_REQ;
            S_STALL_REQ:  if (stall_done)        nxt = S_SWITCHING;
            S_SWITCHING:  if (!ready_s)          nxt = S_WAIT_READY;
            S_WAIT_READY: if (ready_s)           nxt = S_RELEASE;
            S_RELEASE:                           nxt = S_IDLE;
            default:                             nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            applied <= 1'b0;
        else if (state == S_STALL_REQ && nxt == S_SWITCHING)
            applied <= ~applied;
    end

    always_comb begin
        stall   = 1'b0;
        busy    = 1'b1;
        waiting = 1'b0;
        unique case (state)
            S_IDLE:       busy = 1'b0;
            S_STALL_REQ:  begin stall = 1'b1; waiting = 1'b1; end
            S_SWITCHING:  begin stall = 1'b1; waiting = 1'b1; end
            S_WAIT_READY: begin stall = 1'b1; waiting = 1'b1; end
            S_RELEASE:    ;
            default:      busy = 1'b0;
        endcase
    end

    assign leaving    = (nxt != state);
    assign supply_sel = applied;

    // R3: select moves only after a confirmed stall
    p_sel_after_done_r3: assert property (@(posedge clk) disable iff (rst)
        (applied != $past(applied)) |-> ($past(stall_done) && $past(stall)));
    // R4: stall drops only once the new rail is reported ready
    p_release_ready_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> $past(ready_s));
    // R2: leaving IDLE always starts with the stall request
    p_busy_starts_stalled_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> stall);
    // R6: a release cycle separates consecutive sequences
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |=> !stall);
endmodule

// File: rtl/dvs_stall_ctrl.sv
module dvs_stall_ctrl #(
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_req,
    input  logic             stall_done,
    input  logic             supply_ready,
    input  logic [CNT_W-1:0] timeout_lim,
    output logic             stall,
    output logic             supply_sel,
    output logic             busy,
    output logic             timeout_err
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] raw_in, synced;
    logic             waiting, leaving;

    assign raw_in = {supply_ready, mode_req};

    dvs_sync #(.W(NSYNC), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (synced)
    );

    dvs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_s     (synced[0]),
        .ready_s    (synced[1]),
        .stall_done (stall_done),
        .stall      (stall),
        .busy       (busy),
        .supply_sel (supply_sel),
        .waiting    (waiting),
        .leaving    (leaving)
    );

    dvs_watchdog #(.CNT_W(CNT_W)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .waiting (waiting),
        .leaving (leaving),
        .limit   (timeout_lim),
        .err     (timeout_err)
    );

    // R7: the flag never drops the stall
    p_err_keeps_stall_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> stall);
endmodule

// File: tb/sim_dvs_stall_ctrl.sv
module sim_dvs_stall_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_req = 1'b0;
    logic [15:0] timeout_lim = 16'd0;
    logic        stall, supply_sel, busy, timeout_err;
    logic        stall_done, supply_ready;

    logic dp_auto = 1'b0, man_done = 1'b0, dp_done = 1'b0;
    logic sp_auto = 1'b0, man_ready = 1'b1, sp_ready = 1'b1, sp_hang = 1'b0;
    int   dp_delay = 2, dp_cnt = 0;
    int   sp_fall = 1, sp_rise = 3, sp_cnt = 0, sp_ph = 0;
    logic sp_last = 1'b0;

    int checks = 0, errors = 0;
    logic finished = 1'b0;
    logic mon_en = 1'b0;
    logic p_stall = 1'b0, p_done = 1'b0, p_sel = 1'b0, p_rst = 1'b1;
    int   rises = 0, sel_moves = 0, moves_in_seq = 0;

    assign stall_done   = dp_auto ? dp_done : man_done;
    assign supply_ready = sp_auto ? sp_ready : man_ready;

    always #5 clk = ~clk;

    dvs_stall_ctrl u0 (
        .clk(clk), .rst(rst), .mode_req(mode_req), .stall_done(stall_done),
        .supply_ready(supply_ready), .timeout_lim(timeout_lim),
        .stall(stall), .supply_sel(supply_sel), .busy(busy),
        .timeout_err(timeout_err)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        mode_req = 1'b0;
        man_done = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(3);
    endtask

    // guarded-logic model: confirms the stall after dp_delay cycles
    always @(posedge clk) begin
        #2;
        if (stall) begin
            if (dp_cnt >= dp_delay) dp_done = 1'b1;
            else dp_cnt++;
        end else begin
            dp_done = 1'b0;
            dp_cnt = 0;
        end
    end

    // supply model: drops ready after a select change, restores it later
    always @(posedge clk) begin
        #2;
        if (supply_sel != sp_last) begin
            sp_last = supply_sel;
            sp_ph = 1;
            sp_cnt = 0;
        end else if (sp_ph == 1) begin
            if (sp_cnt >= sp_fall) begin sp_ready = 1'b0; sp_ph = 2; sp_cnt = 0; end
            else sp_cnt++;
        end else if (sp_ph == 2) begin
            if (sp_cnt >= sp_rise && !sp_hang) begin sp_ready = 1'b1; sp_ph = 0; end
            else sp_cnt++;
        end
    end

    // ordering monitor
    always @(negedge clk) begin
        if (mon_en && !rst && !p_rst) begin
            if (supply_sel != p_sel) begin
                check("R3 select moved without confirmed stall", int'(p_stall && p_done), 1);
                check("R6 one select move per sequence", moves_in_seq, 0);
                moves_in_seq++;
                sel_moves++;
            end
            if (stall && !p_stall) rises++;
            if (!stall && p_stall)
                check("R4 stall fell while supply not ready", int'(supply_ready), 1);
            if (stall) check("R5 busy during stall", int'(busy), 1);
            if (!busy) moves_in_seq = 0;
        end
        p_stall = stall;
        p_done  = stall_done;
        p_sel   = supply_sel;
        p_rst   = rst;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0, r1;
        void'($urandom(32'd7719));
        tick(1);
        do_reset();
        mon_en = 1'b1;

        // R1 reset state
        check("R1 stall", int'(stall), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 supply_sel", int'(supply_sel), 0);
        check("R1 timeout_err", int'(timeout_err), 0);

        // R10 confirmation while idle is ignored
        man_done = 1'b1;
        tick(5);
        check("R10 sel unchanged", int'(supply_sel), 0);
        check("R10 stall unchanged", int'(stall), 0);
        man_done = 1'b0;
        tick(2);

        // R2 / R3 / R4 / R5 directed sequence, manual handshakes
        timeout_lim = 16'd0;
        mode_req = 1'b1;
        tick(2);
        check("R2 stall not yet", int'(stall), 0);
        tick(1);
        check("R2 stall raised", int'(stall), 1);
        check("R2 busy raised", int'(busy), 1);
        check("R2 sel unchanged", int'(supply_sel), 0);
        tick(4);
        check("R3 sel held without stall_done", int'(supply_sel), 0);
        man_done = 1'b1;
        tick(1);
        check("R3 sel flips on confirmation", int'(supply_sel), 1);
        check("R4 stall held after flip", int'(stall), 1);
        tick(6);
        check("R4 stall held while ready stays high", int'(stall), 1);
        man_ready = 1'b0;
        tick(5);
        check("R4 stall held while ready low", int'(stall), 1);
        man_ready = 1'b1;
        tick(2);
        check("R4 stall held during ready sync", int'(stall), 1);
        tick(1);
        check("R4 stall released", int'(stall), 0);
        check("R5 busy in release", int'(busy), 1);
        man_done = 1'b0;
        tick(1);
        check("R5 busy back to idle", int'(busy), 0);
        tick(4);

        // R6 request changed during a sequence is served afterwards
        dp_auto = 1'b1; sp_auto = 1'b1; sp_ready = 1'b1; sp_last = supply_sel;
        dp_delay = 3; sp_fall = 2; sp_rise = 4;
        r0 = rises; r1 = sel_moves;
        mode_req = 1'b0;
        tick(4);
        mode_req = 1'b1;
        tick(80);
        check("R6 two sequences", rises - r0, 2);
        check("R6 two select moves", sel_moves - r1, 2);
        check("R6 final select", int'(supply_sel), 1);
        check("R6 idle afterwards", int'(busy), 0);

        // R6 double toggle inside a sequence starts nothing more
        r0 = rises;
        mode_req = 1'b0;
        tick(4);
        mode_req = 1'b1;
        tick(2);
        mode_req = 1'b0;
        tick(80);
        check("R6 single sequence", rises - r0, 1);
        check("R6 select after double toggle", int'(supply_sel), 0);

        // R7 confirmation timeout
        dp_auto = 1'b0; sp_auto = 1'b0; man_ready = 1'b1;
        do_reset();
        timeout_lim = 16'd5;
        mode_req = 1'b1;
        tick(3);
        check("R7 stall up", int'(stall), 1);
        tick(5);
        check("R7 no flag before limit", int'(timeout_err), 0);
        tick(1);
        check("R7 flag raised", int'(timeout_err), 1);
        check("R7 stall kept", int'(stall), 1);
        check("R7 sel unchanged", int'(supply_sel), 0);
        tick(10);
        check("R7 flag sticky", int'(timeout_err), 1);

        // R8 supply-ready timeout (ready never drops)
        do_reset();
        timeout_lim = 16'd8;
        mode_req = 1'b1;
        tick(4);
        man_done = 1'b1;
        tick(30);
        check("R8 flag raised", int'(timeout_err), 1);
        check("R8 stall kept", int'(stall), 1);
        check("R8 sel moved", int'(supply_sel), 1);

        // R9 zero limit disables
        do_reset();
        timeout_lim = 16'd0;
        mode_req = 1'b1;
        tick(300);
        check("R9 no flag", int'(timeout_err), 0);
        check("R9 still stalled", int'(stall), 1);

        // random phase
        do_reset();
        timeout_lim = 16'd200;
        dp_auto = 1'b1; sp_auto = 1'b1; sp_hang = 1'b0; sp_ready = 1'b1;
        sp_last = supply_sel; sp_ph = 0;
        for (int i = 0; i < 60; i++) begin
            dp_delay = int'($urandom_range(0, 6));
            sp_fall  = int'($urandom_range(0, 3));
            sp_rise  = int'($urandom_range(0, 6));
            if ($urandom_range(0, 3) != 0) mode_req = ~mode_req;
            tick(int'($urandom_range(1, 50)));
        end
        tick(120);
        check("R6 random final select", int'(supply_sel), int'(mode_req));
        check("R5 random idle", int'(busy), 0);
        check("R7 random no false flag", int'(timeout_err), 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule